// File: doc/BRIEF.md
# Paged Address Window Mapper

This block relates a 36-bit processor physical address space to a 32-bit system-bus address space. The processor space is split into sixteen 4 GB pages. Two 4-bit page registers choose the pages used in each direction. A shared base/bound pair marks a window inside a page that holds processor memory open to the system bus.

Each processor-side request is classified in one of three ways:
- **private**: it lies outside the page chosen by the system page register.
- **local**: it lies inside that page and inside the window, so it stays local.
- **remote**: it lies inside that page but outside the window. Its low 32 bits are forwarded to the system side.

For each system-side request, the block reports whether the address falls in the window and so selects the bridge. On a hit, it extends the address to 36 bits using the processor page register.

Both decodes are registered, with one cycle of latency. A configuration port writes the two page registers, the base and the bound.

Top module: `page_window_map`

## Requirements
- R1: After reset, all outputs are zero, both page registers are 0, and base and bound are 0, so the window is disabled.
- R2: A processor request whose address bits [35:32] differ from the system page register yields kind 0 (private) and a forwarded address of zero.
- R3: A processor request inside the system page with low 32 bits in the window yields kind 1 (local) and a forwarded address of zero.
- R4: A processor request inside the system page with low 32 bits outside the window yields kind 2 (remote) and a forwarded address equal to its low 32 bits.
- R5: A system request with an address inside the window sets hit, and its processor address is {processor page, address}. Outside the window, hit is 0 and the processor address is zero.
- R6: The window includes base and excludes bound. Any bound less than or equal to base makes the window empty.
- R7: Each valid output equals its request input delayed by one clock. When not valid, kind is 0, hit is 0 and both address outputs are zero.
- R8: A configuration write in the same cycle as a request does not affect that request. The write takes effect from the next request.
- R9: The configuration select encodes 0 as system page, 1 as processor page, 2 as base and 3 as bound. A page register takes data bits [3:0]. No register changes while write enable is low.
- R10: When both page registers hold the same value, a processor address in any other page is private. No system request can produce a processor address outside that page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_sel_i | input | 2 | Register select: 0 sys page, 1 proc page, 2 base, 3 bound |
| cfg_data_i | input | 32 | Configuration write data |
| p_req_i | input | 1 | Processor-side request |
| p_addr_i | input | 36 | Processor physical address |
| p_vld_o | output | 1 | Processor decode valid |
| p_kind_o | output | 2 | 0 private, 1 local, 2 remote |
| p_fwd_addr_o | output | 32 | Address forwarded to the system side (remote only) |
| s_req_i | input | 1 | System-side request |
| s_addr_i | input | 32 | System-bus address |
| s_vld_o | output | 1 | System decode valid |
| s_hit_o | output | 1 | Bridge selected as slave |
| s_proc_addr_o | output | 36 | Extended processor address (hit only) |

## Verification
A corrupted page register shows up on the first processor request to an affected page. That request is misclassified one cycle after it is issued. A corrupted page register also shows up in the upper nibble of the next system hit. A wrong base or bound moves the local/remote and hit/miss boundary. The bench therefore probes the words just below and at both base and bound, in every page. This catches an off-by-one limit on the first probe that touches it. A decode that reads configuration combinationally instead of at the request edge shows up in the same-cycle write case: that request is classified under the new settings rather than the old.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef enum logic [1:0] {
    KIND_PRIVATE = 2'd0,
    KIND_LOCAL   = 2'd1,
    KIND_REMOTE  = 2'd2
  } acc_kind_e;

  typedef enum logic [1:0] {
    SEL_SYS_PAGE  = 2'd0,
    SEL_PROC_PAGE = 2'd1,
    SEL_BASE      = 2'd2,
    SEL_BOUND     = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs #(
  parameter int PAGE_W = 4,
  parameter int SYS_AW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        sel_i,
  input  logic [SYS_AW-1:0] data_i,
  output logic [PAGE_W-1:0] sys_page_o,
  output logic [PAGE_W-1:0] proc_page_o,
  output logic [SYS_AW-1:0] base_o,
  output logic [SYS_AW-1:0] bound_o
);
  import pwm_pkg::*;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sys_page_o  <= '0;
      proc_page_o <= '0;
      base_o      <= '0;
      bound_o     <= '0;
    end else if (we_i) begin
      case (cfg_sel_e'(sel_i))
        SEL_SYS_PAGE:  sys_page_o  <= data_i[PAGE_W-1:0];
        SEL_PROC_PAGE: proc_page_o <= data_i[PAGE_W-1:0];
        SEL_BASE:      base_o      <= data_i;
        default:       bound_o     <= data_i;
      endcase
    end
  end

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(sys_page_o) && $stable(proc_page_o) && $stable(base_o) && $stable(bound_o))); // R9
endmodule

// File: rtl/pwm_win_cmp.sv
module pwm_win_cmp #(
  parameter int W = 32
) (
  input  logic [W-1:0] addr_i,
  input  logic [W-1:0] base_i,
  input  logic [W-1:0] bound_i,
  output logic         hit_o
);
  logic open_win;
  logic ge_base;
  logic lt_bound;

  // empty when bound <= base
  assign open_win = bound_i > base_i;
  assign ge_base  = addr_i >= base_i;
  assign lt_bound = addr_i < bound_i;
  assign hit_o    = open_win && ge_base && lt_bound;
endmodule

// File: rtl/page_window_map.sv
module page_window_map #(
  parameter int PROC_AW = 36,
  parameter int SYS_AW  = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [1:0]         cfg_sel_i,
  input  logic [SYS_AW-1:0]  cfg_data_i,
  input  logic               p_req_i,
  input  logic [PROC_AW-1:0] p_addr_i,
  output logic               p_vld_o,
  output logic [1:0]         p_kind_o,
  output logic [SYS_AW-1:0]  p_fwd_addr_o,
  input  logic               s_req_i,
  input  logic [SYS_AW-1:0]  s_addr_i,
  output logic               s_vld_o,
  output logic               s_hit_o,
  output logic [PROC_AW-1:0] s_proc_addr_o
);
  import pwm_pkg::*;

  localparam int PAGE_W = PROC_AW - SYS_AW;

  logic [PAGE_W-1:0] sys_page, proc_page;
  logic [SYS_AW-1:0] base, bound;
  logic              p_win, s_win, p_in_page;

  pwm_cfg_regs #(.PAGE_W(PAGE_W), .SYS_AW(SYS_AW)) u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (cfg_we_i),
    .sel_i       (cfg_sel_i),
    .data_i      (cfg_data_i),
    .sys_page_o  (sys_page),
    .proc_page_o (proc_page),
    .base_o      (base),
    .bound_o     (bound)
  );

  pwm_win_cmp #(.W(SYS_AW)) u_p_win (
    .addr_i  (p_addr_i[SYS_AW-1:0]),
    .base_i  (base),
    .bound_i (bound),
    .hit_o   (p_win)
  );

  pwm_win_cmp #(.W(SYS_AW)) u_s_win (
    .addr_i  (s_addr_i),
    .base_i  (base),
    .bound_i (bound),
    .hit_o   (s_win)
  );

  assign p_in_page = p_addr_i[PROC_AW-1:SYS_AW] == sys_page;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_vld_o      <= 1'b0;
      p_kind_o     <= KIND_PRIVATE;
      p_fwd_addr_o <= '0;
    end else begin
      p_vld_o      <= p_req_i;
      p_kind_o     <= KIND_PRIVATE;
      p_fwd_addr_o <= '0;
      if (p_req_i && p_in_page) begin
        if (p_win) begin
          p_kind_o <= KIND_LOCAL;
        end else begin
          p_kind_o     <= KIND_REMOTE;
          p_fwd_addr_o <= p_addr_i[SYS_AW-1:0];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_vld_o       <= 1'b0;
      s_hit_o       <= 1'b0;
      s_proc_addr_o <= '0;
    end else begin
      s_vld_o       <= s_req_i;
      s_hit_o       <= s_req_i && s_win;
      s_proc_addr_o <= (s_req_i && s_win) ? {proc_page, s_addr_i} : '0;
    end
  end

  AST_P_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    p_req_i |=> p_vld_o); // R7
  AST_P_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !p_vld_o |-> (p_kind_o == KIND_PRIVATE && p_fwd_addr_o == '0)); // R7
  AST_NO_LEAK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p_kind_o != KIND_REMOTE) |-> (p_fwd_addr_o == '0)); // R2
  AST_REMOTE_FWD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p_vld_o && p_kind_o == KIND_REMOTE) |-> (p_fwd_addr_o == $past(p_addr_i[SYS_AW-1:0]))); // R4
  AST_S_EXTEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_hit_o |-> (s_vld_o && s_proc_addr_o[SYS_AW-1:0] == $past(s_addr_i))); // R5
  AST_S_MISS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s_hit_o |-> (s_proc_addr_o == '0)); // R5
  AST_KIND_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    p_kind_o != 2'd3); // R3
endmodule

// File: tb/test_page_window_map.sv
module test_page_window_map;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_data = '0;
  logic        p_req = 1'b0;
  logic [35:0] p_addr = '0;
  logic        p_vld;
  logic [1:0]  p_kind;
  logic [31:0] p_fwd;
  logic        s_req = 1'b0;
  logic [31:0] s_addr = '0;
  logic        s_vld;
  logic        s_hit;
  logic [35:0] s_paddr;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // bench shadow of configuration
  logic [3:0]  m_sys = '0, m_proc = '0;
  logic [31:0] m_base = '0, m_bound = '0;

  always #5 clk = ~clk;

  page_window_map i_page_window_map (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_data_i(cfg_data),
    .p_req_i(p_req), .p_addr_i(p_addr),
    .p_vld_o(p_vld), .p_kind_o(p_kind), .p_fwd_addr_o(p_fwd),
    .s_req_i(s_req), .s_addr_i(s_addr),
    .s_vld_o(s_vld), .s_hit_o(s_hit), .s_proc_addr_o(s_paddr)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit in_win(input logic [31:0] a);
    return (m_bound > m_base) && (a >= m_base) && (a < m_bound);
  endfunction

  task automatic cfg_write(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
    case (sel)
      2'd0: m_sys = d[3:0];
      2'd1: m_proc = d[3:0];
      2'd2: m_base = d;
      default: m_bound = d;
    endcase
  endtask

  task automatic proc_probe(input string req, input logic [35:0] a);
    logic [1:0]  ek;
    logic [31:0] ef;
    @(negedge clk);
    p_req = 1'b1; p_addr = a;
    if (a[35:32] != m_sys) begin ek = 2'd0; ef = '0; end
    else if (in_win(a[31:0])) begin ek = 2'd1; ef = '0; end
    else begin ek = 2'd2; ef = a[31:0]; end
    @(negedge clk);
    p_req = 1'b0;
    chk({req, " vld"}, 64'(p_vld), 64'd1);
    chk({req, " kind"}, 64'(p_kind), 64'(ek));
    chk({req, " fwd"}, 64'(p_fwd), 64'(ef));
  endtask

  task automatic sys_probe(input string req, input logic [31:0] a);
    bit h;
    @(negedge clk);
    s_req = 1'b1; s_addr = a;
    h = in_win(a);
    @(negedge clk);
    s_req = 1'b0;
    chk({req, " svld"}, 64'(s_vld), 64'd1);
    chk({req, " hit"}, 64'(s_hit), 64'(h));
    chk({req, " paddr"}, 64'(s_paddr), h ? 64'({m_proc, a}) : 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] offs [6];
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 p_vld", 64'(p_vld), 0);
    chk("R1 p_kind", 64'(p_kind), 0);
    chk("R1 p_fwd", 64'(p_fwd), 0);
    chk("R1 s_vld", 64'(s_vld), 0);
    chk("R1 s_hit", 64'(s_hit), 0);
    chk("R1 s_paddr", 64'(s_paddr), 0);
    rst_n = 1'b1;
    @(negedge clk);
    proc_probe("R1 disabled window remote", 36'h0_0000_0010);
    sys_probe("R1 disabled window miss", 32'h0000_0010);

    // R7 idle outputs
    @(negedge clk);
    chk("R7 idle vld", 64'(p_vld), 0);
    chk("R7 idle kind", 64'(p_kind), 0);
    chk("R7 idle hit", 64'(s_hit), 0);

    // R9 encodings
    cfg_write(2'd0, 32'hFFFF_FFF3);
    cfg_write(2'd1, 32'h0000_0005);
    cfg_write(2'd2, 32'h0000_1000);
    cfg_write(2'd3, 32'h0000_2000);
    @(negedge clk);
    cfg_sel = 2'd2; cfg_data = 32'hDEAD_BEEF; // we low: must not land
    proc_probe("R9 no write when we low", 36'h3_0000_1000);

    // R2 R3 R4 R6 sweep over all pages and window edges
    offs = '{32'h0, 32'h0FFF, 32'h1000, 32'h1FFF, 32'h2000, 32'hFFFF_FFFF};
    for (int pg = 0; pg < 16; pg++)
      for (int k = 0; k < 6; k++)
        proc_probe("R2/R3/R4 R6 proc sweep", {4'(pg), offs[k]});
    // R5 R6 system sweep
    for (int k = 0; k < 6; k++) sys_probe("R5 R6 sys sweep", offs[k]);

    // R6 empty windows
    cfg_write(2'd3, 32'h0000_1000);
    proc_probe("R6 bound==base remote", 36'h3_0000_1000);
    sys_probe("R6 bound==base miss", 32'h0000_1000);
    cfg_write(2'd3, 32'h0000_0800);
    proc_probe("R6 bound<base remote", 36'h3_0000_0900);
    sys_probe("R6 bound<base miss", 32'h0000_0900);
    cfg_write(2'd3, 32'h0000_2000);

    // R8 same-cycle write does not affect the request
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'd0; cfg_data = 32'h7;
    p_req = 1'b1; p_addr = 36'h3_0000_1800;
    @(negedge clk);
    cfg_we = 1'b0; p_req = 1'b0;
    chk("R8 old page used kind", 64'(p_kind), 64'd1);
    m_sys = 4'h7;
    proc_probe("R8 new page next request", 36'h3_0000_1800);
    proc_probe("R8 new page in effect", 36'h7_0000_1800);

    // R10 equal pages
    cfg_write(2'd0, 32'h9);
    cfg_write(2'd1, 32'h9);
    proc_probe("R10 other page private", 36'h2_0000_1800);
    proc_probe("R10 same page local", 36'h9_0000_1800);
    sys_probe("R10 system reaches only page 9", 32'h0000_1800);
    chk("R10 upper nibble", 64'(s_paddr[35:32]), 64'h9);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule